// File: doc/BRIEF.md
# Byte-Stream Command Decoder with Cross-Domain Fan-Out

This block sits on a byte-wide AXI4-Stream channel clocked in a network domain and turns short command frames into control for two downstream engines, each in its own asynchronous clock domain. One is a pulse generator and the other is a capture unit. Three commands are understood. A reset command produces one single-cycle reset pulse in each engine domain. A start command produces one single-cycle go pulse in each engine domain. A load command carries a twelve-byte little-endian payload that sets the pulse shape. The generator domain receives width, period, count and amplitude. The capture domain receives period and count.

A start puts the decoder into a busy state. The capture unit ends it with a one-cycle completion pulse in its own clock domain. While busy, the stream is still drained, so a frame never stalls, but every byte is discarded. Each pulse crosses domains as a toggle that is synchronized and edge-detected. Configuration is held stable in the network domain and captured in each destination when its update toggle arrives.

The parser is a four-state machine. Its states are ST_IDLE (waiting for an opcode), ST_LOAD (collecting payload), ST_SKIP (dropping the rest of a bad frame) and ST_BUSY (run in progress). Its transitions are as follows:
- ST_IDLE goes to ST_LOAD on a load opcode without tlast.
- ST_IDLE goes to ST_BUSY on a start opcode with tlast.
- ST_IDLE goes to ST_SKIP on any other byte without tlast.
- ST_LOAD goes to ST_IDLE on tlast (the payload is committed only if it was the twelfth payload byte).
- ST_LOAD goes to ST_SKIP when the twelfth payload byte lacks tlast.
- ST_SKIP goes to ST_IDLE on tlast.
- ST_BUSY goes to ST_IDLE on completion, or to ST_SKIP on completion if a frame is part-way through.

Top module: `stream_cmd_ctrl`

## Requirements
- R1: Once reset is released, s_axis_tready is 1 and the block accepts one byte every network cycle.
- R2: A one-byte frame 0x0F with tlast produces exactly one single-cycle gen_reset pulse and exactly one single-cycle cap_reset pulse.
- R3: A one-byte frame 0xF0 with tlast produces exactly one gen_go pulse and exactly one cap_go pulse, and the block becomes busy.
- R4: A frame consisting of 0x88 followed by exactly 12 payload bytes, with tlast on the last of them, updates the configuration. Payload bytes 0..3 are the width and bytes 4..7 are the period, both 32 bits. Bytes 8..9 are the 16-bit count and bytes 10..11 are the 16-bit raw amplitude. Every field is little-endian.
- R5: gen_amp equals the low AMP_W bits (default 12) of the raw amplitude; for example, raw 0x0CDE gives 0xCDE.
- R6: gen_width, gen_period, gen_count and gen_amp carry the loaded values, and cap_period and cap_count carry the same period and count.
- R7: While busy, all bytes are consumed and discarded, no pulse is issued and the configuration is unchanged. A single-cycle cap_done clears busy, after which commands take effect again.
- R8: A frame whose first byte is not 0x0F, 0xF0 or 0x88 changes no output, even if later bytes of it equal opcodes. The parser resumes at the byte after tlast.
- R9: A frame of the wrong length is dropped without changing any output. This covers a reset or start opcode without tlast, and a load with fewer or more than 12 payload bytes.
- R10: While rst_n is low, all configuration outputs are zero and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_net | input | 1 | Stream-side clock |
| clk_gen | input | 1 | Pulse generator domain clock |
| clk_cap | input | 1 | Capture unit domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized into each domain |
| s_axis_tdata | input | 8 | Command or payload byte |
| s_axis_tvalid | input | 1 | Byte valid |
| s_axis_tready | output | 1 | Byte accepted |
| s_axis_tlast | input | 1 | Last byte of the frame |
| cap_done | input | 1 | Single-cycle run completion, clk_cap domain |
| gen_width | output | WIDTH_W | Pulse width, clk_gen domain |
| gen_period | output | PERIOD_W | Pulse period, clk_gen domain |
| gen_count | output | COUNT_W | Pulse count, clk_gen domain |
| gen_amp | output | AMP_W | Truncated pulse amplitude, clk_gen domain |
| cap_period | output | PERIOD_W | Pulse period, clk_cap domain |
| cap_count | output | COUNT_W | Pulse count, clk_cap domain |
| gen_reset | output | 1 | Reset pulse, clk_gen domain |
| cap_reset | output | 1 | Reset pulse, clk_cap domain |
| gen_go | output | 1 | Start pulse, clk_gen domain |
| cap_go | output | 1 | Start pulse, clk_cap domain |

## Verification
Every one of the 256 byte values is sent as a one-byte frame. This separates the two single-byte opcodes from all others, and it separates a lone load opcode (too short) from a real command. Load frames are then sent with every payload length from 1 to 14, using arithmetically generated payloads. Only the length of 12 may change the outputs, and the distinct byte values expose any byte-order or field-placement error. Three further patterns target the remaining behaviour:
- frames whose later bytes look like opcodes, and opcodes sent without tlast, which expose parser resynchronization;
- commands sent during a run, before and after cap_done, which separate discarding from stalling and show that busy is released;
- a mid-run reset, which shows that every output returns to zero.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam logic [7:0] OP_RESET = 8'h0F;
    localparam logic [7:0] OP_START = 8'hF0;
    localparam logic [7:0] OP_LOAD  = 8'h88;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SKIP,
        ST_BUSY
    } scd_state_e;

endpackage

// File: rtl/scd_rst_sync.sv
module scd_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_n_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scd_tgl_sync.sv
module scd_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[DEPTH-2:0], tgl_in};
    end

    assign pulse = sh_q[DEPTH-1] ^ sh_q[DEPTH-2];

    // R2 / R3: a command yields a single-cycle pulse in the destination domain
    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/scd_cfg_xfer.sv
module scd_cfg_xfer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tgl_in,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    logic upd;

    scd_tgl_sync u_upd (
        .clk    (clk),
        .rst_n  (rst_n),
        .tgl_in (tgl_in),
        .pulse  (upd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dst <= '0;
        else if (upd) dst <= src;
    end

    // R6: the destination copy equals the held source word after an update
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (dst == $past(src)));
endmodule

// File: rtl/scd_parser.sv
module scd_parser
    import scd_pkg::*;
#(
    parameter int WIDTH_W   = 32,
    parameter int PERIOD_W  = 32,
    parameter int COUNT_W   = 16,
    parameter int RAW_AMP_W = 16,
    parameter int AMP_W     = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          tdata,
    input  logic                tvalid,
    input  logic                tlast,
    output logic                tready,
    input  logic                done_pulse,
    output logic                rst_tgl,
    output logic                go_tgl,
    output logic                cfg_tgl,
    output logic [WIDTH_W-1:0]  cfg_width,
    output logic [PERIOD_W-1:0] cfg_period,
    output logic [COUNT_W-1:0]  cfg_count,
    output logic [AMP_W-1:0]    cfg_amp
);
    localparam int PAY_W         = WIDTH_W + PERIOD_W + COUNT_W + RAW_AMP_W;
    localparam int PAYLOAD_BYTES = PAY_W / 8;
    localparam int LAST_IDX      = PAYLOAD_BYTES - 1;
    localparam int IDX_W         = $clog2(PAYLOAD_BYTES);
    localparam int OFS_PERIOD    = WIDTH_W;
    localparam int OFS_COUNT     = WIDTH_W + PERIOD_W;
    localparam int OFS_AMP       = WIDTH_W + PERIOD_W + COUNT_W;

    scd_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             mid_q, mid_d;
    logic             ready_q;
    logic [7:0]       buf_q [LAST_IDX];
    logic [PAY_W-1:0] pay_w;

    logic byte_ok, at_last, fire_rst, fire_go, commit;

    assign byte_ok = tvalid && ready_q;
    assign at_last = (idx_q == IDX_W'(LAST_IDX));
    assign tready  = ready_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        mid_d   = byte_ok ? !tlast : mid_q;
        unique case (state_q)
            ST_IDLE: if (byte_ok) begin
                if (tdata == OP_LOAD && !tlast) begin
                    state_d = ST_LOAD;
                    idx_d   = '0;
                end else if (tdata == OP_START && tlast) begin
                    state_d = ST_BUSY;
                end else if (!tlast) begin
                    state_d = ST_SKIP;
                end
            end
            ST_LOAD: if (byte_ok) begin
                if (tlast)        state_d = ST_IDLE;
                else if (at_last) state_d = ST_SKIP;
                else              idx_d   = idx_q + 1'b1;
            end
            ST_SKIP: if (byte_ok && tlast) state_d = ST_IDLE;
            ST_BUSY: if (done_pulse) state_d = mid_d ? ST_SKIP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            mid_q   <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            mid_q   <= mid_d;
            ready_q <= 1'b1;
        end
    end

    // command strobes
    assign fire_rst = (state_q == ST_IDLE) && byte_ok && tlast && (tdata == OP_RESET);
    assign fire_go  = (state_q == ST_IDLE) && byte_ok && tlast && (tdata == OP_START);
    assign commit   = (state_q == ST_LOAD) && byte_ok && tlast && at_last;

    always_comb begin
        for (int i = 0; i < LAST_IDX; i++) pay_w[i*8 +: 8] = buf_q[i];
        pay_w[LAST_IDX*8 +: 8] = tdata;
    end

    // outputs: toggles, payload buffer, held configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_tgl    <= 1'b0;
            go_tgl     <= 1'b0;
            cfg_tgl    <= 1'b0;
            cfg_width  <= '0;
            cfg_period <= '0;
            cfg_count  <= '0;
            cfg_amp    <= '0;
            for (int i = 0; i < LAST_IDX; i++) buf_q[i] <= '0;
        end else begin
            if (fire_rst) rst_tgl <= !rst_tgl;
            if (fire_go)  go_tgl  <= !go_tgl;
            if (state_q == ST_LOAD && byte_ok && !at_last) buf_q[idx_q] <= tdata;
            if (commit) begin
                cfg_tgl    <= !cfg_tgl;
                cfg_width  <= pay_w[0 +: WIDTH_W];
                cfg_period <= pay_w[OFS_PERIOD +: PERIOD_W];
                cfg_count  <= pay_w[OFS_COUNT +: COUNT_W];
                cfg_amp    <= pay_w[OFS_AMP +: AMP_W];
            end
        end
    end

    // R4: payload index never passes the last payload byte
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> (idx_q <= IDX_W'(LAST_IDX)));

    // R4 / R9: configuration update only after a full-length load frame
    assert_commit_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_tgl) |-> ($past(state_q) == ST_LOAD && $past(at_last) && $past(tlast)));

    // R7: no command takes effect while busy
    assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> ($stable(rst_tgl) && $stable(go_tgl) && $stable(cfg_tgl)));

    // R8: an unknown first byte has no effect
    assert_unknown_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && byte_ok && tdata != OP_RESET && tdata != OP_START && tdata != OP_LOAD)
        |=> ($stable(rst_tgl) && $stable(go_tgl) && $stable(cfg_tgl)));

    // R1: the stream is never back-pressured once out of reset
    assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready_q) |-> tready);
endmodule

// File: rtl/stream_cmd_ctrl.sv
module stream_cmd_ctrl #(
    parameter int WIDTH_W   = 32,
    parameter int PERIOD_W  = 32,
    parameter int COUNT_W   = 16,
    parameter int RAW_AMP_W = 16,
    parameter int AMP_W     = 12
) (
    input  logic                clk_net,
    input  logic                clk_gen,
    input  logic                clk_cap,
    input  logic                rst_n,
    input  logic [7:0]          s_axis_tdata,
    input  logic                s_axis_tvalid,
    output logic                s_axis_tready,
    input  logic                s_axis_tlast,
    input  logic                cap_done,
    output logic [WIDTH_W-1:0]  gen_width,
    output logic [PERIOD_W-1:0] gen_period,
    output logic [COUNT_W-1:0]  gen_count,
    output logic [AMP_W-1:0]    gen_amp,
    output logic [PERIOD_W-1:0] cap_period,
    output logic [COUNT_W-1:0]  cap_count,
    output logic                gen_reset,
    output logic                cap_reset,
    output logic                gen_go,
    output logic                cap_go
);
    localparam int GEN_W = WIDTH_W + PERIOD_W + COUNT_W + AMP_W;
    localparam int CAP_W = PERIOD_W + COUNT_W;

    logic net_rst_n, gen_rst_n, cap_rst_n;
    logic rst_tgl, go_tgl, cfg_tgl, done_tgl_q, done_net;

    logic [WIDTH_W-1:0]  cfg_width;
    logic [PERIOD_W-1:0] cfg_period;
    logic [COUNT_W-1:0]  cfg_count;
    logic [AMP_W-1:0]    cfg_amp;

    scd_rst_sync u_rs_net (.clk(clk_net), .rst_n(rst_n), .rst_n_sync(net_rst_n));
    scd_rst_sync u_rs_gen (.clk(clk_gen), .rst_n(rst_n), .rst_n_sync(gen_rst_n));
    scd_rst_sync u_rs_cap (.clk(clk_cap), .rst_n(rst_n), .rst_n_sync(cap_rst_n));

    scd_parser #(
        .WIDTH_W(WIDTH_W), .PERIOD_W(PERIOD_W), .COUNT_W(COUNT_W),
        .RAW_AMP_W(RAW_AMP_W), .AMP_W(AMP_W)
    ) u_parser (
        .clk        (clk_net),
        .rst_n      (net_rst_n),
        .tdata      (s_axis_tdata),
        .tvalid     (s_axis_tvalid),
        .tlast      (s_axis_tlast),
        .tready     (s_axis_tready),
        .done_pulse (done_net),
        .rst_tgl    (rst_tgl),
        .go_tgl     (go_tgl),
        .cfg_tgl    (cfg_tgl),
        .cfg_width  (cfg_width),
        .cfg_period (cfg_period),
        .cfg_count  (cfg_count),
        .cfg_amp    (cfg_amp)
    );

    // completion travels back from the capture domain as a toggle
    always_ff @(posedge clk_cap or negedge cap_rst_n) begin
        if (!cap_rst_n)    done_tgl_q <= 1'b0;
        else if (cap_done) done_tgl_q <= !done_tgl_q;
    end

    scd_tgl_sync u_done (.clk(clk_net), .rst_n(net_rst_n), .tgl_in(done_tgl_q), .pulse(done_net));

    scd_tgl_sync u_gen_rst (.clk(clk_gen), .rst_n(gen_rst_n), .tgl_in(rst_tgl), .pulse(gen_reset));
    scd_tgl_sync u_cap_rst (.clk(clk_cap), .rst_n(cap_rst_n), .tgl_in(rst_tgl), .pulse(cap_reset));
    scd_tgl_sync u_gen_go  (.clk(clk_gen), .rst_n(gen_rst_n), .tgl_in(go_tgl),  .pulse(gen_go));
    scd_tgl_sync u_cap_go  (.clk(clk_cap), .rst_n(cap_rst_n), .tgl_in(go_tgl),  .pulse(cap_go));

    scd_cfg_xfer #(.W(GEN_W)) u_gen_cfg (
        .clk    (clk_gen),
        .rst_n  (gen_rst_n),
        .tgl_in (cfg_tgl),
        .src    ({cfg_amp, cfg_count, cfg_period, cfg_width}),
        .dst    ({gen_amp, gen_count, gen_period, gen_width})
    );

    scd_cfg_xfer #(.W(CAP_W)) u_cap_cfg (
        .clk    (clk_cap),
        .rst_n  (cap_rst_n),
        .tgl_in (cfg_tgl),
        .src    ({cfg_count, cfg_period}),
        .dst    ({cap_count, cap_period})
    );

    // R10: outputs are cleared while reset is held
    assert_reset_clear_R10: assert property (@(posedge clk_gen)
        !gen_rst_n |-> (gen_width == '0 && gen_amp == '0 && !gen_reset && !gen_go));
endmodule

// File: tb/stream_cmd_ctrl_test.sv
`timescale 1ns/1ps
module stream_cmd_ctrl_test;
    localparam int AMP_W = 12;

    logic clk_net = 0, clk_gen = 0, clk_cap = 0, rst_n = 0;
    logic [7:0] s_axis_tdata = 0;
    logic s_axis_tvalid = 0, s_axis_tlast = 0, s_axis_tready, cap_done = 0;
    logic [31:0] gen_width, gen_period, cap_period;
    logic [15:0] gen_count, cap_count;
    logic [AMP_W-1:0] gen_amp;
    logic gen_reset, cap_reset, gen_go, cap_go;

    always #10 clk_net = ~clk_net;   // 50 MHz
    always #9  clk_gen = ~clk_gen;
    always #18 clk_cap = ~clk_cap;

    stream_cmd_ctrl #(.AMP_W(AMP_W)) uut (.*);

    int n_chk = 0, n_err = 0;
    int n_grst = 0, n_crst = 0, n_ggo = 0, n_cgo = 0;
    int e_grst = 0, e_crst = 0, e_ggo = 0, e_cgo = 0;
    logic [31:0] e_w = 0, e_p = 0;
    logic [15:0] e_c = 0, e_a = 0;

    always @(posedge clk_gen) begin
        if (gen_reset) n_grst <= n_grst + 1;
        if (gen_go)    n_ggo  <= n_ggo + 1;
    end
    always @(posedge clk_cap) begin
        if (cap_reset) n_crst <= n_crst + 1;
        if (cap_go)    n_cgo  <= n_cgo + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_pulses(input string req);
        chk(n_grst == e_grst, req, "gen_reset count", n_grst, e_grst);
        chk(n_crst == e_crst, req, "cap_reset count", n_crst, e_crst);
        chk(n_ggo  == e_ggo,  req, "gen_go count",    n_ggo,  e_ggo);
        chk(n_cgo  == e_cgo,  req, "cap_go count",    n_cgo,  e_cgo);
    endtask

    task automatic chk_cfg(input string req);
        chk(gen_width  == e_w, req, "gen_width",  gen_width,  e_w);
        chk(gen_period == e_p, req, "gen_period", gen_period, e_p);
        chk(gen_count  == e_c, req, "gen_count",  gen_count,  e_c);
        chk(gen_amp == e_a[AMP_W-1:0], req, "gen_amp (R5)", gen_amp, e_a[AMP_W-1:0]);
        chk(cap_period == e_p, req, "cap_period", cap_period, e_p);
        chk(cap_count  == e_c, req, "cap_count",  cap_count,  e_c);
    endtask

    function automatic logic [7:0] pbyte(input int k, input int i);
        return 8'((k * 37 + i * 13 + 5) & 255);
    endfunction

    task automatic send_byte(input logic [7:0] d, input logic last);
        @(negedge clk_net);
        s_axis_tdata = d; s_axis_tvalid = 1; s_axis_tlast = last;
    endtask

    task automatic idle_settle();
        @(negedge clk_net);
        s_axis_tvalid = 0; s_axis_tlast = 0; s_axis_tdata = 0;
        repeat (16) @(negedge clk_net);
    endtask

    // opcode then n payload bytes, tlast on the final byte
    task automatic send_load(input int k, input int n);
        send_byte(8'h88, n == 0);
        for (int i = 0; i < n; i++) send_byte(pbyte(k, i), i == n - 1);
        idle_settle();
    endtask

    task automatic expect_load(input int k);
        e_w = {pbyte(k,3), pbyte(k,2), pbyte(k,1), pbyte(k,0)};
        e_p = {pbyte(k,7), pbyte(k,6), pbyte(k,5), pbyte(k,4)};
        e_c = {pbyte(k,9), pbyte(k,8)};
        e_a = {pbyte(k,11), pbyte(k,10)};
    endtask

    task automatic pulse_done();
        @(negedge clk_cap); cap_done = 1;
        @(negedge clk_cap); cap_done = 0;
        repeat (16) @(negedge clk_net);
    endtask

    initial begin
        repeat (150000) @(posedge clk_net);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk_net);
        rst_n = 1;
        repeat (10) @(negedge clk_net);

        // R1 / R10: state after reset
        chk(s_axis_tready == 1, "R1", "tready after reset", s_axis_tready, 1);
        chk_cfg("R10");
        chk_pulses("R10");

        // R2 R3 R8 R9: sweep every value as a one-byte frame
        for (int op = 0; op < 256; op++) begin
            send_byte(8'(op), 1'b1);
            idle_settle();
            if (op == 8'h0F) begin e_grst++; e_crst++; end
            if (op == 8'hF0) begin e_ggo++;  e_cgo++;  end
            chk_pulses(op == 8'h0F ? "R2" : op == 8'hF0 ? "R3" : "R8");
            if (op == 8'hF0) pulse_done();
        end
        chk_cfg("R9");

        // R4 R5 R6 R9: load with every payload length 1..14
        for (int n = 1; n <= 14; n++) begin
            send_load(n, n);
            if (n == 12) expect_load(n);
            chk_cfg(n == 12 ? "R4" : "R9");
        end
        send_load(40, 12); expect_load(40); chk_cfg("R6");

        // R8: opcode-like bytes inside an unknown frame
        send_byte(8'h55, 0); send_byte(8'h0F, 0); send_byte(8'hF0, 0); send_byte(8'h88, 1);
        idle_settle();
        chk_pulses("R8"); chk_cfg("R8");
        send_byte(8'h0F, 1); idle_settle(); e_grst++; e_crst++;
        chk_pulses("R8");

        // R9: single-byte commands without tlast
        send_byte(8'h0F, 0); send_byte(8'h00, 1); idle_settle();
        send_byte(8'hF0, 0); send_byte(8'h00, 1); idle_settle();
        chk_pulses("R9");

        // R7: busy interlock
        send_byte(8'hF0, 1); idle_settle(); e_ggo++; e_cgo++;
        chk_pulses("R3");
        send_byte(8'h0F, 1); idle_settle();
        send_load(77, 12);
        send_byte(8'hF0, 1); idle_settle();
        chk_pulses("R7"); chk_cfg("R7");
        pulse_done();
        send_byte(8'h0F, 1); idle_settle(); e_grst++; e_crst++;
        chk_pulses("R7");
        send_load(78, 12); expect_load(78); chk_cfg("R7");

        // R10: reset in the middle of operation
        rst_n = 0;
        repeat (4) @(negedge clk_net);
        e_w = 0; e_p = 0; e_c = 0; e_a = 0;
        chk_cfg("R10");
        rst_n = 1;
        repeat (16) @(negedge clk_net);
        chk_pulses("R10");
        chk(s_axis_tready == 1, "R1", "tready after re-reset", s_axis_tready, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule